// File: doc/BRIEF.md
# RDS Block Synchronization Detector

This block takes the demodulated RDS bit stream, one bit per `bit_vld` strobe, and finds where each 26-bit block starts and ends. Every block has a 16-bit information word followed by 10 check bits. The check bits are offset by one of six known words (A, B, C, C', D, E). The block looks at the most recent 26 bits, reduces them modulo the RDS generator polynomial, and reads the result as an offset name. A search path proposes a block phase. The protection rules then decide when that phase becomes the held lock and when the lock is given up.

The acquisition count and the flywheel count come from 3-bit inputs. The block samples them while `sync_rst` is high. Once locked, the block emits one result per 26 bits. Each result is either a block whose offset was actually seen, or a block placed only by the flywheel. The blocks that earned the lock are not lost: they are replayed at the output, oldest first, as soon as the lock is declared. The search path keeps running while the block is locked. If the held phase is missing blocks and the search path confirms a different phase, the lock moves to that phase.

Top module: `rds_block_sync`

## Requirements
- R1: A window is the last 26 received bits, first-received bit as the most significant. Its syndrome is the window polynomial modulo x^10+x^8+x^7+x^5+x^4+x^3+1. The syndrome names an offset when it equals one of these 10-bit values: A 0x0FC, B 0x198, C 0x168, C' 0x350, D 0x1B4, E 0x000. Only windows with 26 bits received since the last reset are examined.
- R2: `blk_ofs` encodes the offset as 0=A, 1=B, 2=C, 3=C', 4=D, 5=E. It never carries 6 or 7. After E the only accepted offset is E.
- R3: While unlocked, lock is declared when the search path has a chain of N detections spaced exactly 26 bits apart. Each detection in the chain must be the legal successor of the one before it (A→B, B→C or C', C/C'→D, D→A, E→E). N is the sampled acquisition count, and a count of 0 is treated as 1. `locked` rises only on a bit strobe.
- R4: When lock is declared, the last N detected blocks of the chain are output first, oldest first, with `blk_found`=1. They arrive on consecutive cycles after the strobe that completed the chain.
- R5: While locked, one block is output every 26 bits at the held phase. If the window holds the legal successor of the previous block's offset, the block carries `blk_found`=1 and the detected offset.
- R6: While locked, a boundary window with no offset, or with an offset that is not the legal successor, counts as a miss. The block is still output, with `blk_found`=0, the expected successor offset, and the window's upper 16 bits as information. Such blocks appear only right after a bit strobe.
- R7: Consecutive misses are counted, and a detected block clears the count. The miss that comes when the count already equals the sampled flywheel count drops `locked` and produces no output. A flywheel count of 0 drops lock on the first miss.
- R8: The search path runs in parallel with the lock. If the held phase has at least one pending miss and the search path completes an N-chain at another phase, the lock moves to that phase and the N chain blocks are output as in R4. Lock is also declared at once when a chain completes on the same strobe that drops the lock.
- R9: While `sync_rst` is high, the window, search path, lock and output strobe are cleared and both protection counts are sampled. Changes to the count inputs outside reset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sync_rst | input | 1 | Active-high synchronous reset of the synchronizer; samples the counts |
| bit_vld | input | 1 | Strobe: `bit_in` holds a new demodulated bit |
| bit_in | input | 1 | Demodulated data bit |
| bwd_cnt | input | 3 | Acquisition count (detections needed before lock) |
| fwd_cnt | input | 3 | Flywheel count (misses tolerated while locked) |
| blk_vld | output | 1 | One-cycle strobe: a block result is presented |
| blk_info | output | 16 | Information word of the block |
| blk_ofs | output | 3 | Offset code of the block |
| blk_found | output | 1 | 1 = offset detected, 0 = placed by the flywheel |
| locked | output | 1 | Lock is held |

## Verification
A wrong phase counter or a wrong successor rule in the lock path shows up at the held boundary one block later. It appears as an inserted block (`blk_found`=0) where a detected one was due, or as a wrong offset code. A wrong miss count shows up as `locked` falling one block too early or too late in a run of corrupted blocks. Faults in the search path or in the replay buffer appear within a few cycles of the lock event, as a wrong number, order or content of the replayed blocks. The streams are built so that no offset matches at any bit position other than the intended block ends. Every output block can therefore be predicted exactly, including the flywheel blocks taken from a slipped stream.

// File: rtl/rds_block_sync.sv
module rds_block_sync #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          sync_rst,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic [CW-1:0] bwd_cnt,
  input  logic [CW-1:0] fwd_cnt,
  output logic          blk_vld,
  output logic [15:0]   blk_info,
  output logic [2:0]    blk_ofs,
  output logic          blk_found,
  output logic          locked
);
  localparam int BLK = 26;
  localparam int DEPTH = 1 << CW;
  localparam logic [4:0] LAST = 5'(BLK - 1);
  localparam logic [2:0] OA = 3'd0, OB = 3'd1, OC = 3'd2, OCP = 3'd3, OD = 3'd4, OE = 3'd5;

  logic [BLK-1:0] win, nw;
  logic [4:0]     fill, s_ph, l_ph;
  logic [CW-1:0]  bwd_q, fwd_q, bneed, s_cnt, s_cnt_n, l_miss, wp, rp, fl_n;
  logic [2:0]     s_code, l_code, hcode;
  logic [18:0]    mem [DEPTH];
  logic hit, vt, l_bnd, l_hit, l_drop, lk_stay, s_bnd, s_start, s_ok, s_ev, acq;

  function automatic logic [9:0] synd(input logic [BLK-1:0] w);
    logic [9:0] r;
    r = '0;
    for (int i = BLK - 1; i >= 0; i--) r = {r[8:0], w[i]} ^ (r[9] ? 10'h1B9 : 10'h000);
    return r;
  endfunction

  function automatic logic [2:0] succ(input logic [2:0] p);
    case (p)
      OA:      return OB;
      OB:      return OC;
      OC, OCP: return OD;
      OD:      return OA;
      default: return OE;
    endcase
  endfunction

  function automatic logic acc(input logic [2:0] p, input logic [2:0] c);
    return (c == succ(p)) || (p == OB && c == OCP);
  endfunction

  assign nw = {win[BLK-2:0], bit_in};

  always_comb begin
    hit = 1'b1;
    case (synd(nw))
      10'h0FC: hcode = OA;
      10'h198: hcode = OB;
      10'h168: hcode = OC;
      10'h350: hcode = OCP;
      10'h1B4: hcode = OD;
      10'h000: hcode = OE;
      default: begin hcode = OA; hit = 1'b0; end
    endcase
  end

  assign bneed   = (bwd_q == '0) ? CW'(1) : bwd_q;
  assign vt      = bit_vld && (fill == LAST);
  assign l_bnd   = vt && locked && (l_ph == LAST);
  assign l_hit   = hit && acc(l_code, hcode);
  assign l_drop  = l_bnd && !l_hit && (l_miss >= fwd_q);
  assign lk_stay = locked && !l_drop;
  assign s_bnd   = vt && (s_cnt != '0) && (s_ph == LAST);
  assign s_start = vt && (s_cnt == '0) && hit;
  assign s_ok    = s_bnd && hit && acc(s_code, hcode);
  assign s_ev    = s_start || (s_bnd && hit);
  assign s_cnt_n = s_ok ? ((s_cnt == '1) ? s_cnt : s_cnt + CW'(1)) : (hit ? CW'(1) : '0);
  assign acq     = s_ev && (s_cnt_n >= bneed) && (!lk_stay || (l_miss != '0 && !l_bnd));

  always_ff @(posedge clk)
    if (!sync_rst && s_ev) mem[wp] <= {nw[BLK-1:10], hcode};

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      win <= '0; fill <= '0; bwd_q <= bwd_cnt; fwd_q <= fwd_cnt;
      s_ph <= '0; s_cnt <= '0; s_code <= OA; wp <= '0;
      locked <= 1'b0; l_ph <= '0; l_code <= OA; l_miss <= '0;
      rp <= '0; fl_n <= '0;
      blk_vld <= 1'b0; blk_info <= '0; blk_ofs <= OA; blk_found <= 1'b0;
    end else begin
      blk_vld <= 1'b0;
      if (bit_vld) begin
        win <= nw;
        if (fill != LAST) fill <= fill + 5'd1;
      end
      if (vt) begin
        s_ph <= (s_start || s_bnd) ? 5'd0 : s_ph + 5'd1;
        if (s_start || s_bnd) s_cnt <= s_cnt_n;
        if (s_ev) begin
          s_code <= hcode;
          wp     <= wp + CW'(1);
        end
        if (acq) begin
          locked <= 1'b1; l_ph <= '0; l_code <= hcode; l_miss <= '0;
          fl_n   <= bneed;
          rp     <= wp + CW'(1) - bneed;
        end else if (locked) begin
          l_ph <= l_bnd ? 5'd0 : l_ph + 5'd1;
          if (l_bnd) begin
            if (l_hit) begin
              l_code <= hcode; l_miss <= '0;
              blk_vld <= 1'b1; blk_info <= nw[BLK-1:10]; blk_ofs <= hcode; blk_found <= 1'b1;
            end else if (l_drop) begin
              locked <= 1'b0;
            end else begin
              l_code <= succ(l_code); l_miss <= l_miss + CW'(1);
              blk_vld <= 1'b1; blk_info <= nw[BLK-1:10]; blk_ofs <= succ(l_code); blk_found <= 1'b0;
            end
          end
        end
      end
      if (fl_n != '0) begin
        blk_vld   <= 1'b1;
        {blk_info, blk_ofs} <= mem[rp];
        blk_found <= 1'b1;
        rp   <= rp + CW'(1);
        fl_n <= fl_n - CW'(1);
      end
    end
  end
endmodule

module rds_block_sync_chk (
  input logic       clk,
  input logic       sync_rst,
  input logic       bit_vld,
  input logic       blk_vld,
  input logic [2:0] blk_ofs,
  input logic       blk_found,
  input logic       locked
);
  p_ofs_code_r2: assert property (@(posedge clk) disable iff (sync_rst)
    blk_vld |-> (blk_ofs <= 3'd5));
  p_lock_on_strobe_r3: assert property (@(posedge clk) disable iff (sync_rst)
    $rose(locked) |-> $past(bit_vld));
  p_out_locked_r5: assert property (@(posedge clk) disable iff (sync_rst)
    blk_vld |-> locked);
  p_insert_on_strobe_r6: assert property (@(posedge clk) disable iff (sync_rst)
    (blk_vld && !blk_found) |-> $past(bit_vld));
  p_drop_on_strobe_r7: assert property (@(posedge clk) disable iff (sync_rst)
    $fell(locked) |-> $past(bit_vld));
  p_reset_clears_r9: assert property (@(posedge clk)
    sync_rst |=> (!locked && !blk_vld));
endmodule

bind rds_block_sync rds_block_sync_chk u_chk (.*);

// File: tb/sim_rds_block_sync.sv
module sim_rds_block_sync;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic sync_rst = 1'b1, bit_vld = 1'b0, bit_in = 1'b0;
  logic [2:0] bwd_cnt = 3'd0, fwd_cnt = 3'd0;
  logic blk_vld, blk_found, locked;
  logic [15:0] blk_info;
  logic [2:0] blk_ofs;

  rds_block_sync u0 (.clk(clk), .sync_rst(sync_rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .bwd_cnt(bwd_cnt), .fwd_cnt(fwd_cnt), .blk_vld(blk_vld), .blk_info(blk_info),
    .blk_ofs(blk_ofs), .blk_found(blk_found), .locked(locked));

  localparam int A = 0, B = 1, C = 2, CP = 3, D = 4, E = 5, NONE = 7;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [19:0] expq[$];
  string tagq[$];
  bit sq[$];
  int ck_idx[$];
  bit ck_lk[$];
  string ck_tag[$];
  logic [31:0] rs = 32'h2468_ACE1;

  function automatic logic [15:0] rnd16();
    rs = rs * 32'd1103515245 + 32'd12345;
    return rs[30:15];
  endfunction

  function automatic logic [9:0] bmod(input logic [25:0] v);
    logic [25:0] t;
    t = v;
    for (int j = 25; j >= 10; j--) if (t[j]) t = t ^ (26'h5B9 << (j - 10));
    return t[9:0];
  endfunction

  function automatic logic [9:0] offw(input int c);
    case (c)
      A: return 10'h0FC;  B: return 10'h198;  C: return 10'h168;
      CP: return 10'h350; D: return 10'h1B4;  default: return 10'h000;
    endcase
  endfunction

  function automatic int hitc(input logic [25:0] w);
    for (int c = 0; c < 6; c++) if (bmod(w) == offw(c)) return c;
    return NONE;
  endfunction

  function automatic logic [25:0] win_at(input int k);
    logic [25:0] w;
    for (int i = 0; i < 26; i++) w[25 - i] = sq[k - 25 + i];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ex(input logic [15:0] inf, input int code, input bit found, input string tag);
    expq.push_back({inf, 3'(code), found});
    tagq.push_back(tag);
  endtask

  task automatic ckpt(input int idx, input bit lk, input string tag);
    ck_idx.push_back(idx); ck_lk.push_back(lk); ck_tag.push_back(tag);
  endtask

  task automatic push_blk(input int code, input bit bad, output int endi, output logic [15:0] inf);
    while (1) begin
      logic [15:0] info;
      logic [25:0] cw;
      int n0;
      bit ok;
      info = rnd16(); n0 = sq.size(); ok = 1'b1;
      cw = {info, bmod({info, 10'b0}) ^ offw(code)};
      if (bad) cw[12 + int'(info % 16'd13)] ^= 1'b1;
      for (int i = 25; i >= 0; i--) sq.push_back(cw[i]);
      for (int k = n0; k < n0 + 26; k++)
        if (k >= 25) begin
          if (k == n0 + 25) ok &= (hitc(win_at(k)) == (bad ? NONE : code));
          else ok &= (hitc(win_at(k)) == NONE);
        end
      if (ok) begin endi = n0 + 25; inf = cw[25:10]; return; end
      repeat (26) void'(sq.pop_back());
    end
  endtask

  task automatic push_junk(input int n);
    while (1) begin
      logic [15:0] r;
      int n0;
      bit ok;
      r = rnd16(); n0 = sq.size(); ok = 1'b1;
      for (int i = 0; i < n; i++) sq.push_back(r[i]);
      for (int k = n0; k < n0 + n; k++) if (k >= 25) ok &= (hitc(win_at(k)) == NONE);
      if (ok) return;
      repeat (n) void'(sq.pop_back());
    end
  endtask

  task automatic start(input logic [2:0] b, input logic [2:0] f);
    @(negedge clk);
    sync_rst = 1'b1; bwd_cnt = b; fwd_cnt = f;
    @(negedge clk); @(negedge clk);
    check("R9 reset state", {blk_vld, locked}, 0);
    sync_rst = 1'b0; bwd_cnt = ~b; fwd_cnt = ~f;
  endtask

  task automatic drive();
    for (int i = 0; i < sq.size(); i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = sq[i];
      @(negedge clk); bit_vld = 1'b0;
      while (ck_idx.size() != 0 && ck_idx[0] == i) begin
        check(ck_tag.pop_front(), locked, ck_lk.pop_front());
        void'(ck_idx.pop_front());
      end
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check("R5 all expected blocks seen", expq.size(), 0);
    expq.delete(); tagq.delete(); sq.delete();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk)
    if (blk_vld) begin
      logic [19:0] e;
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected block actual=%0h expected=none", {blk_info, blk_ofs, blk_found});
      end else begin
        e = expq.pop_front();
        check(tagq.pop_front(), {blk_info, blk_ofs, blk_found}, e);
      end
    end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    int e, ea;
    logic [15:0] inf, infd;

    // acquisition 3, flywheel 2
    start(3'd3, 3'd2);
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R4 replay 1");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R4 replay 2");
    push_blk(C, 0, e, inf);  ex(inf, C, 1, "R4 replay 3"); ckpt(e, 1, "R3 lock after 3");
    push_blk(D, 0, e, inf);  ex(inf, D, 1, "R1 detected D");
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R5 detected A");
    push_blk(B, 1, e, inf);  ex(inf, B, 0, "R6 inserted B");
    push_blk(CP, 0, e, inf); ex(inf, CP, 1, "R5 detected C'");
    push_blk(D, 0, e, inf);  ex(inf, D, 1, "R5 detected D");
    push_blk(A, 1, e, inf);  ex(inf, A, 0, "R6 inserted A");
    push_blk(B, 1, e, inf);  ex(inf, B, 0, "R7 second miss kept");
    push_blk(C, 1, e, inf);  ckpt(e, 0, "R7 lock dropped");
    push_blk(D, 0, e, inf);  ex(inf, D, 1, "R4 relock replay 1");
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R4 relock replay 2");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R4 relock replay 3"); ckpt(e, 1, "R3 relock");
    push_blk(C, 0, e, inf);  ex(inf, C, 1, "R5 detected C");
    drive();

    // acquisition 2, flywheel 7, slipped stream
    start(3'd2, 3'd7);
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R4 replay 1");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R9 sampled count 2");
    push_blk(C, 0, e, inf);  ex(inf, C, 1, "R5 detected C");
    push_junk(5);
    push_blk(D, 0, e, infd);
    ex(win_at(e - 5)[25:10], D, 0, "R6 flywheel D");
    push_blk(A, 0, ea, inf);
    ex(win_at(ea - 5)[25:10], A, 0, "R6 flywheel A");
    ex(infd, D, 1, "R8 moved replay 1");
    ex(inf, A, 1, "R8 moved replay 2"); ckpt(ea, 1, "R8 still locked");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R8 new phase B");
    push_blk(C, 0, e, inf);  ex(inf, C, 1, "R5 detected C");
    drive();

    // acquisition 0 (acts as 1), flywheel 1, wrong-position offset
    start(3'd0, 3'd1);
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R3 count 0 locks on first");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R5 detected B");
    push_blk(D, 0, e, inf);  ex(inf, C, 0, "R6 wrong offset inserted as C");
    push_blk(A, 0, e, inf);  ex(inf, A, 1, "R7 relock on drop strobe");
    push_blk(B, 0, e, inf);  ex(inf, B, 1, "R5 detected B");
    push_blk(CP, 0, e, inf); ex(inf, CP, 1, "R2 code 3 for C'");
    drive();

    // E chain, flywheel 0
    start(3'd2, 3'd0);
    push_blk(E, 0, e, inf);  ex(inf, E, 1, "R2 E replay 1");
    push_blk(E, 0, e, inf);  ex(inf, E, 1, "R2 E replay 2");
    push_blk(E, 0, e, inf);  ex(inf, E, 1, "R5 E follows E");
    push_blk(E, 1, e, inf);  ckpt(e, 0, "R7 flywheel 0 drops at once");
    drive();

    start(3'd1, 3'd1);
    finish_up();
  end
endmodule